// File: doc/BRIEF.md
# Amplifier Operating Mode Controller

This block decides which of six operating modes a digital class-D speaker amplifier is in, and drives the enables that follow from that choice. It reads control bits held in a register interface (power-down, speaker enable, speaker mute, amplifier enable and a soft-off option), a flag that reports whether the audio serial clocks are valid, and four protection flags (over-current, over-voltage, under-voltage, over-temperature). From these it selects power-down, suspend, operating, mute, off or fault.

Its outputs enable the audio serial interface, the audio data path and the PWM output stage, where low means the stage floats. It also requests gain ramps from a separate ramp unit, with a direction flag. The ramp unit acknowledges with a done input. Mute and unmute always ramp. A move to off can optionally ramp the gain down before the outputs are released. After a protection event, the block stays in fault mode until every flag has been clear for a full checking window. That window is a parameterised cycle count, about 200 ms at the default setting.

Top module: `amp_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with power-down requested, `mode_o` is 0 (power-down) and `serial_en_o`, `path_en_o`, `pwm_drive_o` and `ramp_req_o` are all 0.
- R2: `mode_o` encodes 0 power-down, 1 suspend, 2 operating, 3 mute, 4 off and 5 fault. Selection priority runs from fault (highest) to power-down, then suspend, then the register-decoded modes. Every output changes on the first rising edge after the inputs that cause the change.
- R3: In power-down (`pwr_down_i`=1), the serial interface, the data path and the PWM stage are all disabled.
- R4: With `clk_valid_i`=0, and neither a fault nor power-down present, the mode is suspend. The serial interface stays enabled, and the data path and PWM stage are off. The block leaves suspend once `clk_valid_i` returns to 1.
- R5: `spk_en_i`=1, `spk_mute_i`=0 and `amp_en_i`=1 select operating mode, with all three enables at 1.
- R6: `spk_en_i`=1, `spk_mute_i`=1 and `amp_en_i`=1 select mute, with all three enables at 1. Moving from operating to mute raises `ramp_req_o` with `ramp_down_o`=1. Moving from mute to operating raises `ramp_req_o` with `ramp_down_o`=0.
- R7: `ramp_req_o` stays high until `ramp_done_i` is sampled high on a rising edge, and it is low after that edge.
- R8: `spk_en_i`=1 with `amp_en_i`=0 selects off, and so does any register combination with `spk_en_i`=0. In off mode the PWM stage and the data path are disabled and the serial interface stays enabled, unless a soft-off ramp is running (R9).
- R9: When `soft_off_i`=1 and the target becomes off while operating, `mode_o` shows off but the PWM stage and data path keep running, and a downward ramp is requested. Both enables drop on the edge that samples `ramp_done_i` high.
- R10: Any one of the four protection flags selects fault mode on the next edge. Fault mode floats the PWM stage, disables the data path and keeps the serial interface enabled.
- R11: Fault mode persists until all flags have been clear for `RECOVER_CYCLES` consecutive edges. The mode changes on the edge after those. A flag that reasserts during the window restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down control bit |
| spk_en_i | input | 1 | Speaker enable control bit |
| spk_mute_i | input | 1 | Speaker mute control bit |
| amp_en_i | input | 1 | Amplifier enable control bit |
| soft_off_i | input | 1 | Ramp down before turning off |
| clk_valid_i | input | 1 | Audio serial clocks valid |
| flt_ocp_i | input | 1 | Over-current flag |
| flt_ovp_i | input | 1 | Over-voltage flag |
| flt_uvp_i | input | 1 | Under-voltage flag |
| flt_otp_i | input | 1 | Over-temperature flag |
| ramp_done_i | input | 1 | Ramp unit finished the requested ramp |
| mode_o | output | 3 | Current mode code |
| serial_en_o | output | 1 | Audio serial interface enable |
| path_en_o | output | 1 | Audio data path enable |
| pwm_drive_o | output | 1 | PWM stage drives (0 = float) |
| ramp_req_o | output | 1 | Gain ramp request |
| ramp_down_o | output | 1 | Ramp direction, 1 = toward mute |

## Verification
Every result, whether mode, enables or ramp request, is registered once. Each is therefore due on the first rising edge after its cause, and the bench drives inputs on falling edges and samples one falling edge later. Fault recovery is the exception. The mode stays in fault through exactly `RECOVER_CYCLES` edges after the flags clear, and changes on the edge after that. The bench checks both sides of that boundary, and checks it again after a flag reasserts partway through the window. Ramp requests are checked while `ramp_done_i` is held low over several cycles, and again on the cycle after a single-cycle acknowledge.

// File: rtl/amp_mode_pkg.sv
package amp_mode_pkg;
  typedef enum logic [2:0] {
    MODE_PWRDN   = 3'd0,
    MODE_SUSPEND = 3'd1,
    MODE_OPERATE = 3'd2,
    MODE_MUTE    = 3'd3,
    MODE_OFF     = 3'd4,
    MODE_FAULT   = 3'd5
  } amp_mode_e;
endpackage

// File: rtl/amp_fault_timer.sv
module amp_fault_timer #(
  parameter int unsigned NUM_FLAGS      = 4,
  parameter int unsigned RECOVER_CYCLES = 25_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 fault_active_o
);
  localparam int unsigned CW = (RECOVER_CYCLES > 1) ? $clog2(RECOVER_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

  logic          any_flag;
  logic          hold_q, hold_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign any_flag = |flags_i;
  assign cnt_en   = any_flag | hold_q;

  always_comb begin
    hold_n = hold_q;
    cnt_n  = cnt_q;
    if (any_flag) begin
      hold_n = 1'b1;
      cnt_n  = '0;
    end else if (hold_q) begin
      if (cnt_q == LAST) begin
        hold_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      hold_q <= hold_n;
      cnt_q  <= cnt_n;
    end
  end

  assign fault_active_o = any_flag | hold_q;

  AST_FLAG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |=> (hold_q && cnt_q == '0));  // R11
  AST_WINDOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !any_flag && cnt_q == LAST) |=> !hold_q);  // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < RECOVER_CYCLES);  // R11
endmodule

// File: rtl/amp_mode_decode.sv
module amp_mode_decode
  import amp_mode_pkg::*;
(
  input  logic      fault_active_i,
  input  logic      pwr_down_i,
  input  logic      clk_valid_i,
  input  logic      spk_en_i,
  input  logic      spk_mute_i,
  input  logic      amp_en_i,
  output amp_mode_e target_o
);
  always_comb begin
    if (fault_active_i)                     target_o = MODE_FAULT;
    else if (pwr_down_i)                    target_o = MODE_PWRDN;
    else if (!clk_valid_i)                  target_o = MODE_SUSPEND;
    else if (spk_en_i && amp_en_i)          target_o = spk_mute_i ? MODE_MUTE : MODE_OPERATE;
    else                                    target_o = MODE_OFF;
  end
endmodule

// File: rtl/amp_mode_fsm.sv
module amp_mode_fsm
  import amp_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  amp_mode_e target_i,
  input  logic      soft_off_i,
  input  logic      ramp_done_i,
  output amp_mode_e mode_o,
  output logic      serial_en_o,
  output logic      path_en_o,
  output logic      pwm_drive_o,
  output logic      ramp_req_o,
  output logic      ramp_down_o
);
  amp_mode_e mode_q, mode_n;
  logic ramp_req_q, ramp_req_n;
  logic ramp_dn_q, ramp_dn_n;
  logic drain_q, drain_n;
  logic serial_q, serial_n;
  logic path_q, path_n;
  logic drive_q, drive_n;
  logic ramp_ack;

  assign ramp_ack = ramp_req_q & ramp_done_i;

  always_comb begin
    mode_n     = target_i;
    ramp_req_n = 1'b0;
    ramp_dn_n  = ramp_dn_q;
    drain_n    = 1'b0;
    case (target_i)
      MODE_OPERATE: begin
        if (mode_q == MODE_MUTE || (mode_q == MODE_OFF && drain_q)) begin
          ramp_req_n = 1'b1;
          ramp_dn_n  = 1'b0;
        end else if (mode_q == MODE_OPERATE) begin
          ramp_req_n = ramp_req_q & ~ramp_ack;
        end
      end
      MODE_MUTE: begin
        if (mode_q == MODE_OPERATE) begin
          ramp_req_n = 1'b1;
          ramp_dn_n  = 1'b1;
        end else if (mode_q == MODE_MUTE) begin
          ramp_req_n = ramp_req_q & ~ramp_ack;
        end
      end
      MODE_OFF: begin
        if (soft_off_i && (mode_q == MODE_OPERATE ||
                           (mode_q == MODE_MUTE && ramp_req_q && !ramp_ack))) begin
          ramp_req_n = 1'b1;
          ramp_dn_n  = 1'b1;
          drain_n    = 1'b1;
        end else if (mode_q == MODE_OFF && drain_q) begin
          drain_n    = ~ramp_ack;
          ramp_req_n = ~ramp_ack;
        end
      end
      default: ;
    endcase
    drive_n  = (target_i == MODE_OPERATE) || (target_i == MODE_MUTE) || drain_n;
    path_n   = drive_n;
    serial_n = (target_i != MODE_PWRDN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_PWRDN;
      ramp_req_q <= 1'b0;
      ramp_dn_q  <= 1'b0;
      drain_q    <= 1'b0;
      serial_q   <= 1'b0;
      path_q     <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      ramp_req_q <= ramp_req_n;
      ramp_dn_q  <= ramp_dn_n;
      drain_q    <= drain_n;
      serial_q   <= serial_n;
      path_q     <= path_n;
      drive_q    <= drive_n;
    end
  end

  assign mode_o      = mode_q;
  assign serial_en_o = serial_q;
  assign path_en_o   = path_q;
  assign pwm_drive_o = drive_q;
  assign ramp_req_o  = ramp_req_q;
  assign ramp_down_o = ramp_dn_q;

  AST_FLOAT_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MODE_PWRDN, MODE_SUSPEND, MODE_FAULT}) |-> !drive_q);  // R10
  AST_MUTE_RAMPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OPERATE && target_i == MODE_MUTE) |=> (ramp_req_q && ramp_dn_q));  // R6
  AST_UNMUTE_RAMPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_MUTE && target_i == MODE_OPERATE) |=> (ramp_req_q && !ramp_dn_q));  // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_req_q && !ramp_done_i && target_i == mode_q) |=> ramp_req_q);  // R7
  AST_SOFT_OFF_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OPERATE && target_i == MODE_OFF && soft_off_i) |=> (drive_q && ramp_req_q));  // R9
endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl
  import amp_mode_pkg::*;
#(
  parameter int unsigned RECOVER_CYCLES = 25_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down_i,
  input  logic       spk_en_i,
  input  logic       spk_mute_i,
  input  logic       amp_en_i,
  input  logic       soft_off_i,
  input  logic       clk_valid_i,
  input  logic       flt_ocp_i,
  input  logic       flt_ovp_i,
  input  logic       flt_uvp_i,
  input  logic       flt_otp_i,
  input  logic       ramp_done_i,
  output logic [2:0] mode_o,
  output logic       serial_en_o,
  output logic       path_en_o,
  output logic       pwm_drive_o,
  output logic       ramp_req_o,
  output logic       ramp_down_o
);
  localparam int unsigned NUM_FLAGS = 4;

  logic [NUM_FLAGS-1:0] flags;
  logic                 fault_active;
  amp_mode_e            target;
  amp_mode_e            mode_cur;

  assign flags = {flt_otp_i, flt_uvp_i, flt_ovp_i, flt_ocp_i};

  amp_fault_timer #(
    .NUM_FLAGS      (NUM_FLAGS),
    .RECOVER_CYCLES (RECOVER_CYCLES)
  ) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .flags_i        (flags),
    .fault_active_o (fault_active)
  );

  amp_mode_decode u_decode (
    .fault_active_i (fault_active),
    .pwr_down_i     (pwr_down_i),
    .clk_valid_i    (clk_valid_i),
    .spk_en_i       (spk_en_i),
    .spk_mute_i     (spk_mute_i),
    .amp_en_i       (amp_en_i),
    .target_o       (target)
  );

  amp_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .target_i    (target),
    .soft_off_i  (soft_off_i),
    .ramp_done_i (ramp_done_i),
    .mode_o      (mode_cur),
    .serial_en_o (serial_en_o),
    .path_en_o   (path_en_o),
    .pwm_drive_o (pwm_drive_o),
    .ramp_req_o  (ramp_req_o),
    .ramp_down_o (ramp_down_o)
  );

  assign mode_o = mode_cur;

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_ocp_i || flt_ovp_i || flt_uvp_i || flt_otp_i) |=> (mode_o == 3'd5));  // R10
  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_i && !fault_active) |=> (mode_o == 3'd0 && !serial_en_o && !pwm_drive_o));  // R3
  AST_SUSPEND_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_valid_i && !pwr_down_i && !fault_active) |=> (mode_o == 3'd1 && !path_en_o));  // R4
endmodule

// File: tb/amp_mode_ctrl_tb_top.sv
module amp_mode_ctrl_tb_top;
  localparam int unsigned L = 8;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_down, spk_en, spk_mute, amp_en, soft_off, clk_valid;
  logic ocp, ovp, uvp, otp, ramp_done;
  logic [2:0] mode;
  logic serial_en, path_en, pwm_drive, ramp_req, ramp_down;

  int total = 0;
  int bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  amp_mode_ctrl #(.RECOVER_CYCLES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down), .spk_en_i(spk_en),
    .spk_mute_i(spk_mute), .amp_en_i(amp_en), .soft_off_i(soft_off),
    .clk_valid_i(clk_valid), .flt_ocp_i(ocp), .flt_ovp_i(ovp),
    .flt_uvp_i(uvp), .flt_otp_i(otp), .ramp_done_i(ramp_done),
    .mode_o(mode), .serial_en_o(serial_en), .path_en_o(path_en),
    .pwm_drive_o(pwm_drive), .ramp_req_o(ramp_req), .ramp_down_o(ramp_down)
  );

  // vector: {pd,en,mute,amp,cvalid, mode[2:0], serial,path,pwm}
  localparam logic [10:0] VEC [NV] = '{
    {5'b11011, 3'd0, 3'b000},  // R3
    {5'b01011, 3'd2, 3'b111},  // R5
    {5'b01111, 3'd3, 3'b111},  // R6
    {5'b01010, 3'd1, 3'b100},  // R4
    {5'b01001, 3'd4, 3'b100},  // R8
    {5'b00011, 3'd4, 3'b100},  // R8
    {5'b00101, 3'd4, 3'b100},  // R8
    {5'b10000, 3'd0, 3'b000},  // R2 power-down over suspend
    {5'b01110, 3'd1, 3'b100},  // R4
    {5'b01011, 3'd2, 3'b111}   // R4 leaves suspend, R5
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_regs(input logic [4:0] v);
    {pwr_down, spk_en, spk_mute, amp_en, clk_valid} = v;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    set_regs(5'b11011);
    soft_off = 1'b0; ocp = 1'b0; ovp = 1'b0; uvp = 1'b0; otp = 1'b0;
    ramp_done = 1'b1;
    step(3);
    // R1 reset state
    chk("R1 mode in reset", 32'(mode), 0);
    chk("R1 enables in reset", {29'd0, serial_en, path_en, pwm_drive}, 0);
    chk("R1 ramp in reset", 32'(ramp_req), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 mode after release", 32'(mode), 0);
    chk("R1 outputs after release", {28'd0, serial_en, path_en, pwm_drive, ramp_req}, 0);

    // table walk (ramp_done held high so ramps clear)
    for (int i = 0; i < NV; i++) begin
      set_regs(VEC[i][10:6]);
      step(1);
      chk($sformatf("R2 vec%0d mode", i), 32'(mode), 32'(VEC[i][5:3]));
      chk($sformatf("R2 vec%0d enables", i), {29'd0, serial_en, path_en, pwm_drive}, 32'(VEC[i][2:0]));
      step(1);
    end

    // R6/R7 mute ramp handshake; currently operating, no ramp pending
    ramp_done = 1'b0;
    set_regs(5'b01111);
    step(1);
    chk("R6 mute mode", 32'(mode), 3);
    chk("R6 mute ramp req/down", {30'd0, ramp_req, ramp_down}, 3);
    chk("R6 mute still drives", 32'(pwm_drive), 1);
    step(3);
    chk("R7 request held", 32'(ramp_req), 1);
    ramp_done = 1'b1;
    step(1);
    ramp_done = 1'b0;
    chk("R7 request dropped", 32'(ramp_req), 0);
    set_regs(5'b01011);
    step(1);
    chk("R6 unmute ramp req/down", {30'd0, ramp_req, ramp_down}, 2);
    chk("R6 unmute mode", 32'(mode), 2);
    ramp_done = 1'b1;
    step(1);
    ramp_done = 1'b0;
    chk("R7 unmute ack", 32'(ramp_req), 0);

    // R9 soft off
    soft_off = 1'b1;
    set_regs(5'b01001);
    step(1);
    chk("R9 mode off", 32'(mode), 4);
    chk("R9 still driving", {30'd0, path_en, pwm_drive}, 3);
    chk("R9 ramp down req", {30'd0, ramp_req, ramp_down}, 3);
    step(2);
    chk("R9 waits for ramp", 32'(pwm_drive), 1);
    ramp_done = 1'b1;
    step(1);
    chk("R9 floats after ramp", {29'd0, path_en, pwm_drive, ramp_req}, 0);

    // R8 plain off
    soft_off = 1'b0;
    set_regs(5'b01011);
    step(2);
    set_regs(5'b01001);
    step(1);
    chk("R8 off immediate float", {29'd0, serial_en, path_en, pwm_drive}, 4);
    chk("R8 no ramp", 32'(ramp_req), 0);

    // R10 each fault flag, then R11 recovery
    set_regs(5'b01011);
    step(1);
    for (int f = 0; f < 4; f++) begin
      {otp, uvp, ovp, ocp} = 4'(1 << f);
      step(1);
      chk($sformatf("R10 flag%0d mode", f), 32'(mode), 5);
      chk($sformatf("R10 flag%0d enables", f), {29'd0, serial_en, path_en, pwm_drive}, 4);
      {otp, uvp, ovp, ocp} = 4'd0;
      step(int'(L) + 1);
      chk($sformatf("R11 flag%0d recovered", f), 32'(mode), 2);
    end
    // R2 fault beats power-down
    set_regs(5'b11011);
    ovp = 1'b1;
    step(1);
    chk("R2 fault over power-down", 32'(mode), 5);
    ovp = 1'b0;
    set_regs(5'b01011);
    step(int'(L));
    chk("R11 held through window", 32'(mode), 5);
    step(1);
    chk("R11 leaves after window", 32'(mode), 2);
    // R11 restart on reassert
    uvp = 1'b1;
    step(1);
    uvp = 1'b0;
    step(int'(L) - 3);
    uvp = 1'b1;
    step(1);
    uvp = 1'b0;
    step(int'(L));
    chk("R11 restarted window holds", 32'(mode), 5);
    step(1);
    chk("R11 restarted window ends", 32'(mode), 2);

    finish_run();
  end
endmodule